// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block produces the raster timing for a non-interlaced composite video framebuffer. A horizontal pixel counter advances on a pixel clock enable taken from the 14.318 MHz master clock. Its wrap event drives a vertical line counter. From the two counts the block derives horizontal sync, horizontal blank, a colour-burst gate, vertical sync and vertical blank, together with an active-video qualifier.

Each timing window is held by a pair of registered flags. An entry flag is set when the count reaches the window's first position, and an exit flag is set when the count reaches the position just past the window. The window is the span in which the entry flag is set and the exit flag is not. Both flags clear only at the counter wrap, so a window opens once per line or frame and cannot re-open inside it. The vertical counter tests for its wrap only on the enabled cycle that ends a scanline.

The current pixel and line positions are exported for framebuffer addressing. A load-window flag marks the vertical blank interval, which is when new pixel data may be written into frame memory.

Top module: `vid_sync_gen`

## Requirements
- R1: `hcount` resets to 0, advances by one on each clock edge with `pix_ce` high, goes from 453 back to 0, and holds its value on any edge with `pix_ce` low.
- R2: `line_wrap` is high exactly when `pix_ce` is high and `hcount` is 453, so one line lasts 454 enabled cycles.
- R3: `vcount` changes only on an edge where `line_wrap` is high. It goes from 261 back to 0, giving 262 lines per frame. `frame_wrap` is high exactly when `line_wrap` is high and `vcount` is 261, which happens once per frame.
- R4: `hsync` is high for `hcount` 10 through 41. It rises on the edge that moves `hcount` to 10, falls on the edge that moves it to 42, and opens only once per line.
- R5: `hblank` is high for `hcount` 0 through 95.
- R6: `burst` is high for `hcount` 50 through 75, which lies inside horizontal blank and after sync.
- R7: `vblank` is high for `vcount` 0 through 21, and `mem_load_ok` equals `vblank`.
- R8: `vsync` is high for `vcount` 3 through 5.
- R9: `active_video` is high exactly when both `hblank` and `vblank` are low.
- R10: A synchronous active-high `rst` sets both counts to 0 with `hblank`, `vblank` and `mem_load_ok` high and `hsync`, `vsync`, `burst`, `active_video` and `line_wrap` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_ce | input | 1 | Pixel clock enable |
| hcount | output | 9 | Pixel position within the line |
| vcount | output | 9 | Line position within the frame |
| line_wrap | output | 1 | Last enabled pixel of a line |
| frame_wrap | output | 1 | Last enabled pixel of a frame |
| hsync | output | 1 | Horizontal sync window |
| hblank | output | 1 | Horizontal blank window |
| burst | output | 1 | Colour-burst gate |
| vsync | output | 1 | Vertical sync window |
| vblank | output | 1 | Vertical blank window |
| mem_load_ok | output | 1 | Frame memory load window |
| active_video | output | 1 | Visible pixel qualifier |

## Verification
The bench samples every window on both sides of its opening and closing counts. A window decoded from the current count instead of the next count would show up there as a one-pixel lag, and an off-by-one stop would show up as a stretched or truncated window. Across a whole frame it measures each line as 454 enabled cycles and counts exactly 262 line wraps and one frame wrap. A vertical counter that advanced on the wrong event, or that tested its wrap off the line boundary, would break one of those counts. It also stalls and toggles the clock enable to catch a counter, or a line-end flag, that ignores `pix_ce`. It applies a reset in the middle of a line to catch a window flag that comes out of reset in the wrong state.

// File: rtl/vt_pkg.sv
package vt_pkg;

  function automatic int unsigned vt_bits(input int unsigned total);
    return (total <= 2) ? 1 : $clog2(total);
  endfunction

  // Next value of a modulo counter: wraps to zero after total-1.
  function automatic logic [15:0] vt_step(input logic [15:0] cur,
                                          input logic [15:0] total);
    return (cur == total - 16'd1) ? 16'd0 : cur + 16'd1;
  endfunction

endpackage

// File: rtl/vt_counter.sv
module vt_counter
  import vt_pkg::*;
#(
  parameter int unsigned TOTAL = 454,
  parameter int unsigned W     = vt_bits(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap
);

  logic [W-1:0] cnt_q;
  logic [15:0]  step_full;
  logic         at_last;

  assign step_full = vt_step(16'(cnt_q), 16'(TOTAL));
  assign at_last   = (cnt_q == W'(TOTAL - 1));
  assign cnt_nxt   = step_full[W-1:0];
  assign wrap      = adv & at_last;
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (adv) cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/vt_window.sv
module vt_window #(
  parameter int unsigned W     = 9,
  parameter int unsigned START = 10,
  parameter int unsigned STOP  = 42
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         clr,
  input  logic [W-1:0] cnt_nxt,
  output logic         open_evt,
  output logic         close_evt,
  output logic         active
);

  localparam logic INIT_OPEN = (START == 0);

  logic entry_q, exit_q;

  assign open_evt  = adv & (cnt_nxt == W'(START));
  assign close_evt = adv & (cnt_nxt == W'(STOP));

  // Entry flag: set has priority so a window that opens at 0 reopens at wrap.
  always_ff @(posedge clk) begin
    if (rst)           entry_q <= INIT_OPEN;
    else if (open_evt) entry_q <= 1'b1;
    else if (clr)      entry_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            exit_q <= 1'b0;
    else if (clr)       exit_q <= 1'b0;
    else if (close_evt) exit_q <= 1'b1;
  end

  assign active = entry_q & ~exit_q;

endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen
  import vt_pkg::*;
#(
  parameter int unsigned H_TOTAL  = 454,
  parameter int unsigned V_TOTAL  = 262,
  parameter int unsigned HS_BEGIN = 10,
  parameter int unsigned HS_END   = 42,
  parameter int unsigned HB_END   = 96,
  parameter int unsigned CB_BEGIN = 50,
  parameter int unsigned CB_END   = 76,
  parameter int unsigned VS_BEGIN = 3,
  parameter int unsigned VS_END   = 6,
  parameter int unsigned VB_END   = 22,
  parameter int unsigned HW       = vt_bits(H_TOTAL),
  parameter int unsigned VW       = vt_bits(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_ce,
  output logic [HW-1:0] hcount,
  output logic [VW-1:0] vcount,
  output logic          line_wrap,
  output logic          frame_wrap,
  output logic          hsync,
  output logic          hblank,
  output logic          burst,
  output logic          vsync,
  output logic          vblank,
  output logic          mem_load_ok,
  output logic          active_video
);

  logic [HW-1:0] h_nxt;
  logic [VW-1:0] v_nxt;
  logic          v_wrap;
  logic          hs_open, hs_close, hb_open, hb_close, cb_open, cb_close;
  logic          vs_open, vs_close, vb_open, vb_close;

  vt_counter #(.TOTAL(H_TOTAL), .W(HW)) u_hcnt (
    .clk(clk), .rst(rst), .adv(pix_ce),
    .cnt(hcount), .cnt_nxt(h_nxt), .wrap(line_wrap)
  );

  vt_counter #(.TOTAL(V_TOTAL), .W(VW)) u_vcnt (
    .clk(clk), .rst(rst), .adv(line_wrap),
    .cnt(vcount), .cnt_nxt(v_nxt), .wrap(v_wrap)
  );

  assign frame_wrap = v_wrap;

  vt_window #(.W(HW), .START(HS_BEGIN), .STOP(HS_END)) u_hsync (
    .clk(clk), .rst(rst), .adv(pix_ce), .clr(line_wrap), .cnt_nxt(h_nxt),
    .open_evt(hs_open), .close_evt(hs_close), .active(hsync)
  );

  vt_window #(.W(HW), .START(0), .STOP(HB_END)) u_hblank (
    .clk(clk), .rst(rst), .adv(pix_ce), .clr(line_wrap), .cnt_nxt(h_nxt),
    .open_evt(hb_open), .close_evt(hb_close), .active(hblank)
  );

  vt_window #(.W(HW), .START(CB_BEGIN), .STOP(CB_END)) u_burst (
    .clk(clk), .rst(rst), .adv(pix_ce), .clr(line_wrap), .cnt_nxt(h_nxt),
    .open_evt(cb_open), .close_evt(cb_close), .active(burst)
  );

  vt_window #(.W(VW), .START(VS_BEGIN), .STOP(VS_END)) u_vsync (
    .clk(clk), .rst(rst), .adv(line_wrap), .clr(frame_wrap), .cnt_nxt(v_nxt),
    .open_evt(vs_open), .close_evt(vs_close), .active(vsync)
  );

  vt_window #(.W(VW), .START(0), .STOP(VB_END)) u_vblank (
    .clk(clk), .rst(rst), .adv(line_wrap), .clr(frame_wrap), .cnt_nxt(v_nxt),
    .open_evt(vb_open), .close_evt(vb_close), .active(vblank)
  );

  assign mem_load_ok  = vblank;
  assign active_video = ~hblank & ~vblank;

endmodule

// File: rtl/vid_sync_gen_chk.sv
module vid_sync_gen_chk #(
  parameter int unsigned H_TOTAL  = 454,
  parameter int unsigned V_TOTAL  = 262,
  parameter int unsigned HS_BEGIN = 10,
  parameter int unsigned HS_END   = 42,
  parameter int unsigned HW       = 9,
  parameter int unsigned VW       = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_ce,
  input logic [HW-1:0] hcount,
  input logic [VW-1:0] vcount,
  input logic          line_wrap,
  input logic          frame_wrap,
  input logic          hsync,
  input logic          hblank,
  input logic          burst,
  input logic          vsync,
  input logic          vblank
);

  AST_HCOUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    hcount < HW'(H_TOTAL)); // R1

  AST_HCOUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pix_ce |=> $stable(hcount)); // R1

  AST_VCOUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !line_wrap |=> $stable(vcount)); // R3

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> (hcount == '0) && (vcount == '0)); // R3

  AST_VCOUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    vcount < VW'(V_TOTAL)); // R3

  AST_HSYNC_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> hcount == HW'(HS_BEGIN)); // R4

  AST_HSYNC_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync) |-> hcount == HW'(HS_END)); // R4

  AST_BURST_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
    burst |-> hblank && !hsync); // R6

  AST_VSYNC_IN_VBLANK: assert property (@(posedge clk) disable iff (rst)
    vsync |-> vblank); // R8

endmodule

bind vid_sync_gen vid_sync_gen_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HS_BEGIN(HS_BEGIN), .HS_END(HS_END),
  .HW(HW), .VW(VW)
) u_chk (
  .clk(clk), .rst(rst), .pix_ce(pix_ce), .hcount(hcount), .vcount(vcount),
  .line_wrap(line_wrap), .frame_wrap(frame_wrap), .hsync(hsync),
  .hblank(hblank), .burst(burst), .vsync(vsync), .vblank(vblank)
);

// File: tb/vid_sync_gen_tb.sv
`timescale 1ns/1ps
module vid_sync_gen_tb;

  localparam int CLK_PERIOD = 70;
  localparam int N_VEC      = 21;

  logic       clk = 1'b0;
  logic       rst;
  logic       pix_ce;
  logic [8:0] hcount, vcount;
  logic       line_wrap, frame_wrap, hsync, hblank, burst, vsync, vblank;
  logic       mem_load_ok, active_video;

  int applied = 0;
  int bad     = 0;
  int lw_seen = 0;
  int fw_seen = 0;
  int per_cnt = 0;
  int per_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_sync_gen u_dut (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .hcount(hcount), .vcount(vcount),
    .line_wrap(line_wrap), .frame_wrap(frame_wrap), .hsync(hsync),
    .hblank(hblank), .burst(burst), .vsync(vsync), .vblank(vblank),
    .mem_load_ok(mem_load_ok), .active_video(active_video)
  );

  // Vector: {h, v, flags{hsync,hblank,burst,vsync,vblank,active,load}, req}
  typedef struct packed {
    logic [8:0] h;
    logic [8:0] v;
    logic [6:0] flags;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{9'd0,   9'd0,   7'b0100101, 4'd5},  // R5 blank at line start
    '{9'd9,   9'd0,   7'b0100101, 4'd4},  // R4 before sync
    '{9'd10,  9'd0,   7'b1100101, 4'd4},  // R4 sync opens
    '{9'd41,  9'd0,   7'b1100101, 4'd4},  // R4 last sync pixel
    '{9'd42,  9'd0,   7'b0100101, 4'd4},  // R4 sync closed
    '{9'd49,  9'd0,   7'b0100101, 4'd6},  // R6 before burst
    '{9'd50,  9'd0,   7'b0110101, 4'd6},  // R6 burst opens
    '{9'd75,  9'd0,   7'b0110101, 4'd6},  // R6 last burst pixel
    '{9'd76,  9'd0,   7'b0100101, 4'd6},  // R6 burst closed
    '{9'd95,  9'd0,   7'b0100101, 4'd5},  // R5 last blank pixel
    '{9'd96,  9'd0,   7'b0000101, 4'd5},  // R5 blank closed
    '{9'd453, 9'd2,   7'b0000101, 4'd8},  // R8 before vsync
    '{9'd0,   9'd3,   7'b0101101, 4'd8},  // R8 vsync opens
    '{9'd453, 9'd5,   7'b0001101, 4'd8},  // R8 last vsync line
    '{9'd0,   9'd6,   7'b0100101, 4'd8},  // R8 vsync closed
    '{9'd453, 9'd21,  7'b0000101, 4'd7},  // R7 last vblank line
    '{9'd0,   9'd22,  7'b0100000, 4'd7},  // R7 vblank closed
    '{9'd96,  9'd22,  7'b0000010, 4'd9},  // R9 first visible pixel
    '{9'd10,  9'd100, 7'b1100000, 4'd4},  // R4 sync mid-frame
    '{9'd453, 9'd261, 7'b0000010, 4'd9},  // R9 last visible pixel
    '{9'd0,   9'd0,   7'b0100101, 4'd3}   // R3 frame wrapped
  };

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] flags_now();
    return {hsync, hblank, burst, vsync, vblank, active_video, mem_load_ok};
  endfunction

  // Called at a falling edge: record wraps and line period, then advance.
  task automatic step;
    if (pix_ce) per_cnt++;
    if (line_wrap) begin
      lw_seen++;
      if (per_cnt != 454) per_bad++;
      per_cnt = 0;
    end
    if (frame_wrap) fw_seen++;
    @(negedge clk);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0x%0h expected=0x%0h", hcount, 0);
    report();
  end

  initial begin
    rst = 1'b1;
    pix_ce = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(hcount == 0 && vcount == 0, "R10 counts", {hcount, vcount}, 0);
    check(flags_now() == 7'b0100101 && !line_wrap, "R10 flags",
          {flags_now(), line_wrap}, {7'b0100101, 1'b0});
    rst = 1'b0;

    for (int i = 0; i < N_VEC; i++) begin
      while (!(hcount == VECS[i].h && vcount == VECS[i].v)) step();
      check(flags_now() == VECS[i].flags, $sformatf("R%0d vec%0d", VECS[i].req, i),
            flags_now(), VECS[i].flags);
    end

    // R2 every line 454 enabled cycles; R3 262 lines and one frame wrap
    check(per_bad == 0, "R2 line period", per_bad, 0);
    check(lw_seen == 262, "R3 lines per frame", lw_seen, 262);
    check(fw_seen == 1, "R3 frame wraps", fw_seen, 1);

    // R1 enable low freezes the count
    pix_ce = 1'b0;
    repeat (5) @(negedge clk);
    check(hcount == 0 && vcount == 0, "R1 hold", hcount, 0);

    // R1/R4 alternate enable: 10 enabled edges
    for (int k = 0; k < 20; k++) begin
      pix_ce = (k % 2 == 0);
      @(negedge clk);
    end
    check(hcount == 10, "R1 gated count", hcount, 10);
    check(hsync == 1'b1, "R4 sync at gated 10", hsync, 1);

    // R2 line end needs the enable
    pix_ce = 1'b1;
    while (hcount != 453) @(negedge clk);
    pix_ce = 1'b0;
    #1;
    check(line_wrap == 1'b0, "R2 wrap gated off", line_wrap, 0);
    pix_ce = 1'b1;
    #1;
    check(line_wrap == 1'b1, "R2 wrap at 453", line_wrap, 1);
    @(negedge clk);
    check(hcount == 0 && vcount == 1, "R1 wrap to zero", {hcount, vcount}, {9'd0, 9'd1});

    // R10 reset in mid line
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(hcount == 0 && vcount == 0, "R10 mid-line counts", {hcount, vcount}, 0);
    check(flags_now() == 7'b0100101, "R10 mid-line flags", flags_now(), 7'b0100101);
    rst = 1'b0;
    report();
  end

endmodule